// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block steers a classic five-stage integer pipeline (fetch, decode with register read, execute, memory, writeback). It looks at the decoded register numbers and control flags held in the decode, execute, memory and writeback stages. From them it produces bypass mux selects for both ALU operands and for both inputs of the decode-stage branch comparator. It also raises a stall that freezes the PC and the fetch/decode register while a no-operation with every write enable cleared goes into the decode/execute register. A third output is a flush that squashes the one wrong-path instruction fetched behind a taken branch.

Register reads happen in decode and writes happen in writeback, so read-after-write is the only hazard to handle. Results still in the memory or writeback pipeline registers are bypassed. A load followed at once by a consumer of its result costs one bubble. Branches are predicted not taken and resolved in decode. A taken branch costs one squashed slot. A branch whose operands are not yet available waits in decode. The whole block is combinational; the clock and reset only qualify its checks.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: An ALU source that equals a nonzero destination being written by the instruction in the memory stage gets select code 2'b10 (from the memory-stage register).
- R2: An ALU source that matches only a nonzero destination being written from the writeback stage gets select code 2'b01.
- R3: When both the memory-stage and the writeback-stage writers match a source, the memory-stage (younger) result wins with code 2'b10.
- R4: Register 0 is never bypassed: a source of 0 gets code 2'b00 even when a writer targets register 0.
- R5: With no matching writer, or with write enables low, the select is 2'b00 (register file value).
- R6: A load in execute whose nonzero destination equals a source that the decode instruction actually uses raises stall; an unused source field or a load to register 0 does not.
- R7: No stall is raised for a non-branch consumer of an ALU result in execute, or of a load that has reached the memory stage.
- R8: A branch in decode stalls when a source it uses matches a nonzero writer in execute (ALU or load), or a load in the memory stage.
- R9: The branch comparator inputs get bypass selects under the same codes, priority and register-0 rule as the ALU operands.
- R10: Flush is raised exactly when a branch in decode has its condition met and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample checks |
| rst_n | input | 1 | Active-low reset, disables checks |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_hit | input | 1 | Decode comparator reports the branch condition met |
| ex_rs1 | input | 5 | First source of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source of the execute-stage instruction |
| ex_rd | input | 5 | Destination of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination of the writeback-stage instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| alu_sel_a | output | 2 | Bypass select for ALU operand A |
| alu_sel_b | output | 2 | Bypass select for ALU operand B |
| br_sel_a | output | 2 | Bypass select for comparator input A |
| br_sel_b | output | 2 | Bypass select for comparator input B |
| stall | output | 1 | Hold PC and fetch/decode, insert bubble |
| flush | output | 1 | Squash the instruction fetched after a taken branch |

## Verification
The checks assume the stage fields describe a legal pipeline: a load always also carries its write enable, and each flag is meaningful only for its own stage. The checks also assume that the condition input is only consulted while a branch sits in decode. The directed stimulus builds each scenario from an all-idle baseline and sets a load's write enable together with its load flag. Each case sets only the fields it exercises, so every expected select and stall follows from a single hazard pattern.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
`timescale 1ns/1ps
module hz_fwd_pick
   import hz_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_we,
   output fwd_sel_e          sel
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic src_live;
   logic mem_hit;
   logic wb_hit;

   assign src_live = (src != ZERO_REG);
   assign mem_hit  = src_live && mem_we && (mem_rd == src);
   assign wb_hit   = src_live && wb_we  && (wb_rd  == src);

   always_comb begin
      if (mem_hit)     sel = FWD_MEM;
      else if (wb_hit) sel = FWD_WB;
      else             sel = FWD_RF;
   end

   // R4
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == ZERO_REG) |-> (sel == FWD_RF));

   // R3
   younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && wb_we && mem_rd == src && wb_rd == src && src != ZERO_REG)
         |-> (sel == FWD_MEM));

   // R5
   no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we && !wb_we) |-> (sel == FWD_RF));
endmodule

// File: rtl/hz_hazard_detect.sv
`timescale 1ns/1ps
module hz_hazard_detect #(
   parameter int REG_AW        = 5,
   parameter bit DECODE_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use_rs1,
   input  logic              id_use_rs2,
   input  logic              id_is_branch,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_we,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_we,
   output logic              stall
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic hit_ex, hit_mem, hit_wb;
   logic load_use;
   logic br_wait;

   // A used, nonzero source matching a given destination
   function automatic logic uses_reg(input logic [REG_AW-1:0] rd,
                                     input logic [REG_AW-1:0] s1,
                                     input logic [REG_AW-1:0] s2,
                                     input logic u1,
                                     input logic u2);
      return (rd != ZERO_REG) && ((u1 && s1 == rd) || (u2 && s2 == rd));
   endfunction

   assign hit_ex  = uses_reg(ex_rd,  id_rs1, id_rs2, id_use_rs1, id_use_rs2);
   assign hit_mem = uses_reg(mem_rd, id_rs1, id_rs2, id_use_rs1, id_use_rs2);
   assign hit_wb  = uses_reg(wb_rd,  id_rs1, id_rs2, id_use_rs1, id_use_rs2);

   assign load_use = ex_load && hit_ex;

   generate
      if (DECODE_BYPASS) begin : g_byp
         // comparator can take memory/writeback results; only loads and
         // execute-stage writers force a wait
         assign br_wait = id_is_branch &&
                          ((ex_we && hit_ex) || (mem_load && hit_mem));
         logic unused_wb;
         assign unused_wb = wb_we & hit_wb & mem_we;
      end else begin : g_nobyp
         // comparator reads only the register file: wait until writeback
         assign br_wait = id_is_branch &&
                          ((ex_we && hit_ex) || (mem_we && hit_mem) ||
                           (wb_we && hit_wb) || (mem_load && hit_mem));
      end
   endgenerate

   assign stall = load_use || br_wait;

   // R6
   load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load && ex_rd != ZERO_REG && id_use_rs1 && id_rs1 == ex_rd) |-> stall);

   // R7
   alu_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_is_branch && !ex_load) |-> !stall);

   // R8
   br_load_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_is_branch && mem_load && mem_rd != ZERO_REG &&
       id_use_rs2 && id_rs2 == mem_rd) |-> stall);
endmodule

// File: rtl/hz_branch_ctl.sv
`timescale 1ns/1ps
module hz_branch_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic id_is_branch,
   input  logic id_br_hit,
   input  logic stall,
   output logic flush
);
   assign flush = id_is_branch && id_br_hit && !stall;

   // R10
   flush_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (id_is_branch && id_br_hit));
endmodule

// File: rtl/hz_pipe_ctrl.sv
`timescale 1ns/1ps
module hz_pipe_ctrl
   import hz_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter bit DECODE_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use_rs1,
   input  logic              id_use_rs2,
   input  logic              id_is_branch,
   input  logic              id_br_hit,
   input  logic [REG_AW-1:0] ex_rs1,
   input  logic [REG_AW-1:0] ex_rs2,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_we,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_we,
   output logic [1:0]        alu_sel_a,
   output logic [1:0]        alu_sel_b,
   output logic [1:0]        br_sel_a,
   output logic [1:0]        br_sel_b,
   output logic              stall,
   output logic              flush
);
   localparam int N_PICK = 4;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("hz_pipe_ctrl: REG_AW out of range");
   end

   logic [REG_AW-1:0] pick_src [N_PICK];
   fwd_sel_e          pick_sel [N_PICK];

   assign pick_src[0] = ex_rs1;
   assign pick_src[1] = ex_rs2;
   assign pick_src[2] = id_rs1;
   assign pick_src[3] = id_rs2;

   generate
      for (genvar i = 0; i < N_PICK; i++) begin : g_pick
         if (i < 2 || DECODE_BYPASS) begin : g_on
            hz_fwd_pick #(.REG_AW(REG_AW)) u_pick (
               .clk    (clk),
               .rst_n  (rst_n),
               .src    (pick_src[i]),
               .mem_rd (mem_rd),
               .mem_we (mem_we),
               .wb_rd  (wb_rd),
               .wb_we  (wb_we),
               .sel    (pick_sel[i])
            );
         end else begin : g_off
            assign pick_sel[i] = FWD_RF;
         end
      end
   endgenerate

   assign alu_sel_a = pick_sel[0];
   assign alu_sel_b = pick_sel[1];
   assign br_sel_a  = pick_sel[2];
   assign br_sel_b  = pick_sel[3];

   hz_hazard_detect #(.REG_AW(REG_AW), .DECODE_BYPASS(DECODE_BYPASS)) u_haz (
      .clk          (clk),
      .rst_n        (rst_n),
      .id_rs1       (id_rs1),
      .id_rs2       (id_rs2),
      .id_use_rs1   (id_use_rs1),
      .id_use_rs2   (id_use_rs2),
      .id_is_branch (id_is_branch),
      .ex_rd        (ex_rd),
      .ex_we        (ex_we),
      .ex_load      (ex_load),
      .mem_rd       (mem_rd),
      .mem_we       (mem_we),
      .mem_load     (mem_load),
      .wb_rd        (wb_rd),
      .wb_we        (wb_we),
      .stall        (stall)
   );

   hz_branch_ctl u_br (
      .clk          (clk),
      .rst_n        (rst_n),
      .id_is_branch (id_is_branch),
      .id_br_hit    (id_br_hit),
      .stall        (stall),
      .flush        (flush)
   );

   // R1
   mem_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_rd == ex_rs1 && ex_rs1 != '0) |-> (alu_sel_a == 2'b10));

   // R2
   wb_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && wb_rd == ex_rs2 && ex_rs2 != '0 && !(mem_we && mem_rd == ex_rs2))
         |-> (alu_sel_b == 2'b01));

   // R10
   stall_blocks_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !flush);

   // R8
   br_ex_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_is_branch && ex_we && ex_rd != '0 && id_use_rs1 && id_rs1 == ex_rd)
         |-> stall);
endmodule

// File: tb/tb_hz_pipe_ctrl.sv
`timescale 1ns/1ps
module tb_hz_pipe_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic       id_use_rs1, id_use_rs2, id_is_branch, id_br_hit;
   logic       ex_we, ex_load, mem_we, mem_load, wb_we;
   logic [1:0] alu_sel_a, alu_sel_b, br_sel_a, br_sel_b;
   logic       stall, flush;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   hz_pipe_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
      .id_is_branch(id_is_branch), .id_br_hit(id_br_hit),
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
      .ex_we(ex_we), .ex_load(ex_load),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load),
      .wb_rd(wb_rd), .wb_we(wb_we),
      .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
      .br_sel_a(br_sel_a), .br_sel_b(br_sel_b),
      .stall(stall), .flush(flush)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0;
      id_is_branch = 0; id_br_hit = 0;
      ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_we = 0; ex_load = 0;
      mem_rd = '0; mem_we = 0; mem_load = 0; wb_rd = '0; wb_we = 0;
   endtask

   // apply at the falling edge, sample 1 ns later (pure combinational paths)
   task automatic settle();
      #1;
   endtask

   task automatic t_reset_state();
      @(negedge clk); idle(); settle();
      chk("R5 idle sel_a", alu_sel_a, 0);
      chk("R5 idle sel_b", alu_sel_b, 0);
      chk("R6 idle stall", stall, 0);
      chk("R10 idle flush", flush, 0);
   endtask

   task automatic t_mem_fwd();
      @(negedge clk); idle();
      ex_rs1 = 5'd3; ex_rs2 = 5'd9; mem_rd = 5'd3; mem_we = 1; settle();
      chk("R1 mem fwd a", alu_sel_a, 2);
      chk("R1 other operand untouched", alu_sel_b, 0);
   endtask

   task automatic t_wb_fwd();
      @(negedge clk); idle();
      ex_rs2 = 5'd7; wb_rd = 5'd7; wb_we = 1; mem_rd = 5'd8; mem_we = 1; settle();
      chk("R2 wb fwd b", alu_sel_b, 1);
   endtask

   task automatic t_priority();
      @(negedge clk); idle();
      ex_rs1 = 5'd5; ex_rs2 = 5'd5;
      mem_rd = 5'd5; mem_we = 1; wb_rd = 5'd5; wb_we = 1; settle();
      chk("R3 prio a", alu_sel_a, 2);
      chk("R3 prio b", alu_sel_b, 2);
   endtask

   task automatic t_zero_reg();
      @(negedge clk); idle();
      mem_we = 1; wb_we = 1; settle();
      chk("R4 r0 not fwd a", alu_sel_a, 0);
      chk("R4 r0 not fwd b", alu_sel_b, 0);
      id_is_branch = 1; id_use_rs1 = 1; ex_we = 1; ex_load = 1; settle();
      chk("R4 r0 never stalls", stall, 0);
   endtask

   task automatic t_no_writer();
      @(negedge clk); idle();
      ex_rs1 = 5'd3; mem_rd = 5'd3; mem_we = 0; wb_rd = 5'd3; wb_we = 0; settle();
      chk("R5 disabled writers", alu_sel_a, 0);
      ex_rs1 = 5'd4; mem_we = 1; wb_we = 1; settle();
      chk("R5 no match", alu_sel_a, 0);
   endtask

   task automatic t_load_use();
      @(negedge clk); idle();
      ex_rd = 5'd4; ex_we = 1; ex_load = 1; id_rs2 = 5'd4; id_use_rs2 = 1; settle();
      chk("R6 load-use stall", stall, 1);
      id_use_rs2 = 0; settle();
      chk("R6 unused field no stall", stall, 0);
      id_rs1 = 5'd4; id_use_rs1 = 1; settle();
      chk("R6 load-use rs1 stall", stall, 1);
   endtask

   task automatic t_no_stall();
      @(negedge clk); idle();
      ex_rd = 5'd4; ex_we = 1; id_rs1 = 5'd4; id_use_rs1 = 1; settle();
      chk("R7 alu producer no stall", stall, 0);
      idle(); mem_rd = 5'd4; mem_we = 1; mem_load = 1;
      id_rs2 = 5'd4; id_use_rs2 = 1; settle();
      chk("R7 load in mem no stall", stall, 0);
   endtask

   task automatic t_branch_wait();
      @(negedge clk); idle();
      id_is_branch = 1; id_br_hit = 1; id_rs1 = 5'd6; id_use_rs1 = 1;
      ex_rd = 5'd6; ex_we = 1; settle();
      chk("R8 branch on ex alu stall", stall, 1);
      chk("R10 no flush while stalled", flush, 0);
      ex_we = 0; ex_rd = '0; mem_rd = 5'd6; mem_we = 1; mem_load = 1; settle();
      chk("R8 branch on mem load stall", stall, 1);
   endtask

   task automatic t_branch_fwd();
      @(negedge clk); idle();
      id_is_branch = 1; id_br_hit = 1;
      id_rs1 = 5'd6; id_use_rs1 = 1; id_rs2 = 5'd11; id_use_rs2 = 1;
      mem_rd = 5'd6; mem_we = 1; wb_rd = 5'd11; wb_we = 1; settle();
      chk("R9 br sel a mem", br_sel_a, 2);
      chk("R9 br sel b wb", br_sel_b, 1);
      chk("R8 no stall when bypassable", stall, 0);
      chk("R10 taken flush", flush, 1);
      id_br_hit = 0; settle();
      chk("R10 not taken no flush", flush, 0);
      id_is_branch = 0; id_br_hit = 1; settle();
      chk("R10 non-branch no flush", flush, 0);
      wb_rd = 5'd6; id_rs2 = 5'd6; settle();
      chk("R9 br prio", br_sel_b, 2);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      t_reset_state();
      @(negedge clk); rst_n = 1'b1;
      t_mem_fwd();
      t_wb_fwd();
      t_priority();
      t_zero_reg();
      t_no_writer();
      t_load_use();
      t_no_stall();
      t_branch_wait();
      t_branch_fwd();
      @(negedge clk); idle();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule